// File: doc/BRIEF.md
# Sensor Digital Video Port Formatter

This block sits between an image sensor's readout sequencer and the parallel video pins. It receives one 10-bit converter sample per cycle, together with three qualifiers. One marks an active row, one marks an active frame, and one flags the dark reference pixels that lead each row. From these it produces a registered data bus, horizontal and vertical sync, a pixel-clock enable, a pixel-clock edge select and a drive enable for the pad tristate buffers.

Two byte-wide configuration registers are written through an address/data write port and read back on the same address. One register, at address 0x53, holds the clock and sync controls. The other, at address 0x54, holds the output, dark-pixel and bit-routing controls. A write goes into a staging copy first. The copy that steers the outputs is reloaded from the staging copy only while no frame is active, so the sync style never changes in the middle of a frame. Each sync output can run as a level that covers its period or as a fixed-length pulse after the period ends. The output bus can be rotated so that the converter MSB lands on any selected bit.

Top module: `vid_port_fmt`

## Requirements
- R1: After reset, register 0x53 reads 0x0C and register 0x54 reads 0xF0. The outputs are vid_d=0, vid_hs=1, vid_vs=1, pclk_en=1, pclk_inv=1 and drv_en=1.
- R2: A write with cfg_we=1 stores all 8 bits of cfg_wdata, reserved bits included, into the register at cfg_addr (0x53 or 0x54). cfg_rdata shows the stored value of the register at cfg_addr one cycle later. Writes to any other address are ignored, and other addresses read as 0.
- R3: Stored settings steer the outputs only after a cycle with frame_act=0. While frame_act=1, a write has no effect on the outputs.
- R4: A pixel is valid when frame_act=1, row_act=1, and either dark_pix=0 or dark enable (0x54 bit 6) is 1. One cycle after a valid pixel, vid_d carries that pixel's routed sample. After any other cycle, vid_d is 0.
- R5: Routing code n (0x54 bits 3:0) with n from 0 to 9 rotates the sample left by n, so the output is {A[9-n:0], A[9:10-n]}. Codes 10 to 15 pass the sample straight through.
- R6: With hsync style (0x53 bit 5) at 0, vid_hs is the registered row-valid flag (any valid pixel). With hsync polarity (0x53 bit 0) at 1 it is high when valid and low otherwise; with polarity 0 it is the inverse.
- R7: With hsync style at 1, the cycle after the last valid pixel of a row has left vid_d, vid_hs pulses for exactly 4 cycles. The pulse is low-going with polarity 1 and high-going with polarity 0. At all other times vid_hs rests at the opposite level.
- R8: vid_vs follows the rules of R6 and R7 applied to frame_act. The style is set by 0x53 bit 6 and the polarity by 0x53 bit 1. The level form lags frame_act by one cycle, and the pulse starts one cycle after frame_act falls.
- R9: With dark enable at 1, dark pixels are output and count as row-valid, so the hsync level edge lines up with the first dark pixel. With dark enable at 0, dark pixels give vid_d=0 and do not count as row-valid.
- R10: With clock style (0x53 bit 7) at 0, pclk_en is 1 on every cycle. With clock style at 1, pclk_en one cycle later equals the pixel-valid flag of R4.
- R11: drv_en follows the output enable (0x54 bit 7) and pclk_inv follows the edge bit (0x54 bit 5), each with a one-cycle register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address, used for writes and reads |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored value of the addressed register, one cycle later |
| smp_data | input | 10 | Converter sample |
| row_act | input | 1 | Row readout in progress |
| frame_act | input | 1 | Frame readout in progress |
| dark_pix | input | 1 | Current sample is a dark reference pixel |
| vid_d | output | 10 | Routed video data |
| vid_hs | output | 1 | Horizontal sync |
| vid_vs | output | 1 | Vertical sync |
| pclk_en | output | 1 | Pixel clock gate enable |
| pclk_inv | output | 1 | Pixel clock edge select |
| drv_en | output | 1 | Drive enable for all video pads |

## Verification
Every output is a single register stage behind the inputs. The sample, the qualifiers and the active settings of one cycle therefore all show up at the next rising edge. A sync pulse covers the four edges that follow the edge at which the falling qualifier is seen. A register write is seen on cfg_rdata at the edge after the read address is presented. The new setting steers the outputs only from the edge after the next cycle with frame_act=0. The driver predicts every output for the edge that follows each driven cycle and queues that prediction. The monitor compares the queued item one time unit after that edge, so each check lands on the one cycle in which the result is due.

// File: rtl/vid_fmt_pkg.sv
package vid_fmt_pkg;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 8;
  localparam int SMP_W     = 10;
  localparam int SHIFT_W   = 4;
  localparam int PULSE_LEN = 4;

  localparam logic [CFG_AW-1:0] ADDR_SYNC = 8'h53;
  localparam logic [CFG_AW-1:0] ADDR_OUT  = 8'h54;
  localparam logic [CFG_DW-1:0] RST_SYNC  = 8'h0C;
  localparam logic [CFG_DW-1:0] RST_OUT   = 8'hF0;

  typedef struct packed {
    logic       gate_clk;
    logic       vs_pulse;
    logic       hs_pulse;
    logic       spare4;
    logic [1:0] spare32;
    logic       vs_pol;
    logic       hs_pol;
  } sync_cfg_t;

  typedef struct packed {
    logic               oe;
    logic               dark_en;
    logic               clk_edge;
    logic               spare4;
    logic [SHIFT_W-1:0] route;
  } out_cfg_t;
endpackage

// File: rtl/vid_cfg_regs.sv
module vid_cfg_regs
  import vid_fmt_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int DW = CFG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_act,
  output logic [DW-1:0] rdata,
  output sync_cfg_t     act_sync,
  output out_cfg_t      act_out
);
  logic [DW-1:0] stg_sync, stg_out;

  // staging copies: software-visible, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_sync <= RST_SYNC;
      stg_out  <= RST_OUT;
      rdata    <= '0;
    end else begin
      if (we && addr == ADDR_SYNC) stg_sync <= wdata;
      if (we && addr == ADDR_OUT)  stg_out  <= wdata;
      if (addr == ADDR_SYNC)       rdata <= stg_sync;
      else if (addr == ADDR_OUT)   rdata <= stg_out;
      else                         rdata <= '0;
    end
  end

  // active copies: reloaded only between frames
  always_ff @(posedge clk) begin
    if (rst) begin
      act_sync <= sync_cfg_t'(RST_SYNC);
      act_out  <= out_cfg_t'(RST_OUT);
    end else if (!frame_act) begin
      act_sync <= sync_cfg_t'(stg_sync);
      act_out  <= out_cfg_t'(stg_out);
    end
  end

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    frame_act |=> ($stable(act_sync) && $stable(act_out)));

  assert_bad_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (addr != ADDR_SYNC && addr != ADDR_OUT) |=> rdata == '0);
endmodule

// File: rtl/vid_rotate.sv
module vid_rotate #(
  parameter int W  = 10,
  parameter int SW = 4
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] code,
  output logic [W-1:0]  dout
);
  localparam logic [SW-1:0] LIMIT = SW'(W);
  logic [2*W-1:0] dbl;
  logic [SW-1:0]  amt;

  assign dbl = {din, din};
  assign amt = (code < LIMIT) ? code : '0;

  // out[i] = din[(i - amt) mod W]
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = dbl[i + W - int'(amt)];
  end
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int   PLEN    = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic act_in,
  input  logic pulse_mode,
  input  logic pol,
  output logic sync_o
);
  localparam int CW = (PLEN > 2) ? $clog2(PLEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(PLEN - 1);

  logic          act_d;
  logic [CW-1:0] cnt, cnt_nx;
  logic          fall, pulse_nx;

  always_comb begin
    fall     = act_d & ~act_in;
    pulse_nx = fall | (cnt != '0);
    if (fall)            cnt_nx = LOAD;
    else if (cnt != '0)  cnt_nx = cnt - 1'b1;
    else                 cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d  <= 1'b0;
      cnt    <= '0;
      sync_o <= RST_VAL;
    end else begin
      act_d  <= act_in;
      cnt    <= cnt_nx;
      if (pulse_mode) sync_o <= pol ? ~pulse_nx : pulse_nx;
      else            sync_o <= pol ? act_in : ~act_in;
    end
  end

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && act_d && !act_in) |=> (sync_o != $past(pol)));

  assert_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode) |=> (sync_o == ($past(act_in) ~^ $past(pol))));
endmodule

// File: rtl/vid_port_fmt.sv
module vid_port_fmt
  import vid_fmt_pkg::*;
#(
  parameter int W    = SMP_W,
  parameter int SW   = SHIFT_W,
  parameter int PLEN = PULSE_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic [W-1:0]      smp_data,
  input  logic              row_act,
  input  logic              frame_act,
  input  logic              dark_pix,
  output logic [W-1:0]      vid_d,
  output logic              vid_hs,
  output logic              vid_vs,
  output logic              pclk_en,
  output logic              pclk_inv,
  output logic              drv_en
);
  sync_cfg_t     cs;
  out_cfg_t      co;
  logic          pix_ok;
  logic [W-1:0]  routed;

  vid_cfg_regs #(.AW(CFG_AW), .DW(CFG_DW)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_act(frame_act), .rdata(cfg_rdata), .act_sync(cs), .act_out(co)
  );

  assign pix_ok = frame_act & row_act & (~dark_pix | co.dark_en);

  vid_rotate #(.W(W), .SW(SW)) rot_i (
    .din(smp_data), .code(co.route), .dout(routed)
  );

  vid_sync_gen #(.PLEN(PLEN), .RST_VAL(1'b1)) hs_i (
    .clk(clk), .rst(rst), .act_in(pix_ok), .pulse_mode(cs.hs_pulse),
    .pol(cs.hs_pol), .sync_o(vid_hs)
  );

  vid_sync_gen #(.PLEN(PLEN), .RST_VAL(1'b1)) vs_i (
    .clk(clk), .rst(rst), .act_in(frame_act), .pulse_mode(cs.vs_pulse),
    .pol(cs.vs_pol), .sync_o(vid_vs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_d    <= '0;
      pclk_en  <= 1'b1;
      pclk_inv <= 1'b1;
      drv_en   <= 1'b1;
    end else begin
      vid_d    <= pix_ok ? routed : '0;
      pclk_en  <= cs.gate_clk ? pix_ok : 1'b1;
      pclk_inv <= co.clk_edge;
      drv_en   <= co.oe;
    end
  end

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !pix_ok |=> vid_d == '0);

  assert_free_clk_R10: assert property (@(posedge clk) disable iff (rst)
    !cs.gate_clk |=> pclk_en);

  assert_drive_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drv_en == $past(co.oe)));

  assert_dark_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (dark_pix && !co.dark_en) |=> vid_d == '0);
endmodule

// File: tb/vid_port_fmt_tb_top.sv
module vid_port_fmt_tb_top;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h53, cfg_wdata = 8'h00, cfg_rdata;
  logic [9:0] smp_data = '0, vid_d;
  logic       row_act = 1'b0, frame_act = 1'b0, dark_pix = 1'b0;
  logic       vid_hs, vid_vs, pclk_en, pclk_inv, drv_en;

  int checks = 0, errors = 0;
  int seed = 7;

  always #(CLK_PER/2) clk = ~clk;

  vid_port_fmt dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_data(smp_data),
    .row_act(row_act), .frame_act(frame_act), .dark_pix(dark_pix),
    .vid_d(vid_d), .vid_hs(vid_hs), .vid_vs(vid_vs), .pclk_en(pclk_en),
    .pclk_inv(pclk_inv), .drv_en(drv_en)
  );

  typedef struct {
    logic [9:0] d;
    logic hs, vs, pen, pinv, drv;
    logic [7:0] rd;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [7:0] m_sa = 8'h0C, m_sb = 8'hF0, m_aa = 8'h0C, m_ab = 8'hF0;
  logic m_hok = 1'b0, m_fok = 1'b0;
  int m_hc = 0, m_vc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] rotl(logic [9:0] a, logic [3:0] n);
    if (n > 4'd9) return a;
    return 10'((a << n) | (a >> (10 - n)));
  endfunction

  // driver: apply one cycle of stimulus, queue what the next edge must show
  task automatic step(logic [9:0] s, logic r, logic f, logic k,
                      logic we, logic [7:0] a, logic [7:0] wd);
    exp_t e;
    logic ok, hf, hp, vf, vp;
    smp_data = s; row_act = r; frame_act = f; dark_pix = k;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    ok = f & r & (~k | m_ab[6]);
    e.d = ok ? rotl(s, m_ab[3:0]) : 10'd0;
    hf = m_hok & ~ok; hp = hf || (m_hc != 0);
    m_hc = hf ? 3 : (m_hc != 0 ? m_hc - 1 : 0);
    vf = m_fok & ~f;  vp = vf || (m_vc != 0);
    m_vc = vf ? 3 : (m_vc != 0 ? m_vc - 1 : 0);
    e.hs = m_aa[5] ? (m_aa[0] ? ~hp : hp) : (m_aa[0] ? ok : ~ok);
    e.vs = m_aa[6] ? (m_aa[1] ? ~vp : vp) : (m_aa[1] ? f : ~f);
    e.pen = m_aa[7] ? ok : 1'b1;
    e.drv = m_ab[7];
    e.pinv = m_ab[5];
    e.rd = (a == 8'h53) ? m_sa : (a == 8'h54) ? m_sb : 8'h00;
    m_hok = ok; m_fok = f;
    if (!f) begin m_aa = m_sa; m_ab = m_sb; end
    if (we && a == 8'h53) m_sa = wd;
    if (we && a == 8'h54) m_sb = wd;
    q.push_back(e);
    @(negedge clk);
  endtask

  function automatic logic [9:0] nxt();
    seed = seed * 1103515245 + 12345;
    return seed[25:16];
  endfunction

  task automatic idle(logic f, int n);
    for (int i = 0; i < n; i++) step(10'h0, 1'b0, f, 1'b0, 1'b0, 8'h53, 8'h0);
  endtask

  task automatic wr(logic f, logic [7:0] a, logic [7:0] d);
    step(10'h0, 1'b0, f, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(logic [7:0] a);
    step(10'h0, 1'b0, frame_act, 1'b0, 1'b0, a, 8'h0);
  endtask

  task automatic row(int nb, int np);
    idle(1'b1, 2);
    for (int i = 0; i < nb; i++) step(nxt(), 1'b1, 1'b1, 1'b1, 1'b0, 8'h53, 8'h0);
    for (int i = 0; i < np; i++) step(nxt(), 1'b1, 1'b1, 1'b0, 1'b0, 8'h53, 8'h0);
    idle(1'b1, 6);
  endtask

  // optional write in the first frame cycle exercises R3
  task automatic frame(int nr, int nb, int np, logic we, logic [7:0] a, logic [7:0] d);
    step(10'h0, 1'b0, 1'b1, 1'b0, we, a, d);
    for (int i = 0; i < nr; i++) row(nb, np);
    idle(1'b0, 8);
  endtask

  // monitor: compare one unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R4/R5/R9 vid_d", vid_d, e.d);
      chk("R6/R7/R9 vid_hs", vid_hs, e.hs);
      chk("R3/R8 vid_vs", vid_vs, e.vs);
      chk("R10 pclk_en", pclk_en, e.pen);
      chk("R11 drv_en", drv_en, e.drv);
      chk("R11 pclk_inv", pclk_inv, e.pinv);
      chk("R2 cfg_rdata", cfg_rdata, e.rd);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: output reset values
    chk("R1 vid_d", vid_d, 0);
    chk("R1 vid_hs", vid_hs, 1);
    chk("R1 vid_vs", vid_vs, 1);
    chk("R1 pclk_en", pclk_en, 1);
    chk("R1 pclk_inv", pclk_inv, 1);
    chk("R1 drv_en", drv_en, 1);
    rst = 1'b0;
    // R1: register reset values via readback
    rd(8'h53); rd(8'h54); rd(8'h53);
    frame(2, 8, 6, 1'b0, 8'h53, 8'h0);
    // R2: reserved bits stored; gated clock, pulse syncs, inverted polarity
    wr(1'b0, 8'h53, 8'hFF); rd(8'h53); idle(1'b0, 2);
    frame(2, 8, 6, 1'b0, 8'h53, 8'h0);
    // R7: positive pulses on hsync, level vsync
    wr(1'b0, 8'h53, 8'h20); idle(1'b0, 2);
    frame(2, 8, 6, 1'b0, 8'h53, 8'h0);
    // R3: mid-frame write waits for the next frame gap
    frame(2, 8, 6, 1'b1, 8'h54, 8'h33);
    frame(2, 8, 6, 1'b1, 8'h53, 8'hC3);
    frame(1, 8, 6, 1'b0, 8'h53, 8'h0);
    // R5: every routing code, with dark enable / output enable varied
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc;
      cc = 4'(c);
      wr(1'b0, 8'h54, {cc[0], cc[1], cc[2], 1'b0, cc}); idle(1'b0, 1);
      frame(1, 3, 5, 1'b0, 8'h53, 8'h0);
    end
    // R2: unknown address ignored and reads zero
    wr(1'b0, 8'h55, 8'hA5); rd(8'h55); rd(8'h53); rd(8'h54);
    idle(1'b0, 4);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule